// File: doc/BRIEF.md
# Table-Driven Note Duration Counter

This block sets how long a sound channel stays audible. A 5-bit duration code selects an entry from a fixed table of 32 durations. The four upper bits pick a row and the lowest bit picks a column. When the code differs from the value it held in the previous cycle, the selected duration is written into an 8-bit down-counter. The counter then steps down by one on each frame tick, a single-cycle enable on the system clock that occurs at 120 Hz, and it stops at zero. While the freeze input is high, the count holds its value.

The channel uses the `silent` output to mute its waveform. The frame tick comes from outside the block.

A small state machine tracks the counter. It has three states:
- **ST_SILENT**: the count is zero.
- **ST_RUN**: the count is non-zero and is free to step down.
- **ST_HOLD**: the count is non-zero and frozen.

On every clock edge, the next state follows from the next count and the freeze input:
- If the next count is zero, the next state is ST_SILENT.
- Otherwise, if freeze is high, the next state is ST_HOLD.
- Otherwise, the next state is ST_RUN.

So any state can move to any other state. ST_SILENT moves to ST_RUN or ST_HOLD on a load. ST_RUN moves to ST_SILENT on the last tick. ST_HOLD and ST_RUN swap places when freeze changes. Reset forces ST_SILENT.

Top module: `note_len_timer`

## Requirements
- R1: A synchronous active-high reset clears the count to 0 and records the present code, so after release a code that has not changed causes no load.
- R2: For an even code (bit 0 = 0), bits 4:1 select the loaded duration. Rows 0 to 15 give hex 0A, 14, 28, 50, A0, 3C, 0E, 1A, 0C, 18, 30, 60, C0, 48, 10, 20.
- R3: For an odd code (bit 0 = 1), row 0 loads hex FE and every other row r loads 2*r.
- R4: A code that differs from the previous cycle's code loads the decoded duration, and the new count is visible one clock later. A code held steady reloads nothing.
- R5: With freeze low and no load, a frame tick lowers a non-zero count by exactly one. A cycle without a tick leaves the count unchanged.
- R6: While freeze is high and no load occurs, the count holds even when a tick arrives.
- R7: At zero the count stays at zero under ticks and never wraps.
- R8: When a load and a tick arrive in the same cycle, the load takes effect and no decrement is applied.
- R9: `silent` is high exactly when the count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | Single-cycle decrement enable at the frame rate |
| freeze | input | 1 | High holds the count |
| dur_code | input | 5 | Duration code: bits 4:1 row, bit 0 column |
| count | output | 8 | Present remaining duration |
| silent | output | 1 | High when the count is zero |

## Verification
On every cycle, the in-line assertions check the following:
- the single-step decrement;
- the hold under freeze;
- the hold at zero;
- the precedence of a load over a tick;
- that the mute flag agrees with the count.

The assertions cannot tell whether a loaded value is the correct table entry, or whether reset suppresses a startup load. The bench scenarios show these by walking every code, holding a code after reset, and repeating a code to prove that no reload happens.

// File: rtl/nlt_pkg.sv
package nlt_pkg;
    typedef enum logic [1:0] {
        ST_SILENT = 2'd0,
        ST_RUN    = 2'd1,
        ST_HOLD   = 2'd2
    } nlt_state_e;
endpackage

// File: rtl/nlt_decode.sv
module nlt_decode #(
    parameter int CODE_W = 5,
    parameter int CNT_W  = 8
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  dur
);
    localparam int ROW_W = CODE_W - 1;
    localparam int ROWS  = 1 << ROW_W;

    logic [ROW_W-1:0] row;
    logic [CNT_W-1:0] odd_col [ROWS];
    logic [CNT_W-1:0] even_val;

    assign row = code[CODE_W-1:1];

    // Odd column: row 0 is the longest entry, the rest are even steps.
    for (genvar r = 0; r < ROWS; r++) begin : g_odd
        if (r == 0) begin : g_top
            assign odd_col[r] = CNT_W'(254);
        end else begin : g_step
            assign odd_col[r] = CNT_W'(2 * r);
        end
    end

    // Even column: irregular musical lengths.
    always_comb begin
        unique case (row)
            4'h0: even_val = CNT_W'(8'h0A);
            4'h1: even_val = CNT_W'(8'h14);
            4'h2: even_val = CNT_W'(8'h28);
            4'h3: even_val = CNT_W'(8'h50);
            4'h4: even_val = CNT_W'(8'hA0);
            4'h5: even_val = CNT_W'(8'h3C);
            4'h6: even_val = CNT_W'(8'h0E);
            4'h7: even_val = CNT_W'(8'h1A);
            4'h8: even_val = CNT_W'(8'h0C);
            4'h9: even_val = CNT_W'(8'h18);
            4'hA: even_val = CNT_W'(8'h30);
            4'hB: even_val = CNT_W'(8'h60);
            4'hC: even_val = CNT_W'(8'hC0);
            4'hD: even_val = CNT_W'(8'h48);
            4'hE: even_val = CNT_W'(8'h10);
            4'hF: even_val = CNT_W'(8'h20);
            default: even_val = '0;
        endcase
    end

    assign dur = code[0] ? odd_col[row] : even_val;
endmodule

// File: rtl/nlt_change_det.sv
module nlt_change_det #(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code,
    output logic              load
);
    logic [CODE_W-1:0] prev_code;

    // Reset also captures the code so startup causes no load (R1).
    always_ff @(posedge clk) begin
        if (rst) prev_code <= code;
        else     prev_code <= code;
    end

    assign load = !rst && (code != prev_code);
endmodule

// File: rtl/nlt_core.sv
module nlt_core
    import nlt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             freeze,
    input  logic             load,
    input  logic [CNT_W-1:0] dur,
    output logic [CNT_W-1:0] count,
    output logic             silent
);
    nlt_state_e       state, state_n;
    logic [CNT_W-1:0] count_n;

    always_comb begin
        if (load)
            count_n = dur;
        else if (tick && !freeze && count != '0)
            count_n = count - CNT_W'(1);
        else
            count_n = count;

        if (count_n == '0)  state_n = ST_SILENT;
        else if (freeze)    state_n = ST_HOLD;
        else                state_n = ST_RUN;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_SILENT;
            count <= '0;
        end else begin
            state <= state_n;
            count <= count_n;
        end
    end

    always_comb begin
        unique case (state)
            ST_SILENT: silent = 1'b1;
            ST_RUN:    silent = 1'b0;
            ST_HOLD:   silent = 1'b0;
            default:   silent = 1'b1;
        endcase
    end

    a_r4_load_takes_dur: assert property (@(posedge clk) disable iff (rst)
        load |=> count == $past(dur));
    a_r5_single_step: assert property (@(posedge clk) disable iff (rst)
        (!load && tick && !freeze && count != '0) |=> count == $past(count) - CNT_W'(1));
    a_r6_freeze_holds: assert property (@(posedge clk) disable iff (rst)
        (!load && freeze) |=> $stable(count));
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (!load && count == '0) |=> count == '0);
    a_r8_load_beats_tick: assert property (@(posedge clk) disable iff (rst)
        (load && tick) |=> count == $past(dur));
    a_r9_silent_flag: assert property (@(posedge clk) disable iff (rst)
        silent == (count == '0));
endmodule

// File: rtl/note_len_timer.sv
module note_len_timer #(
    parameter int CODE_W = 5,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_tick,
    input  logic              freeze,
    input  logic [CODE_W-1:0] dur_code,
    output logic [CNT_W-1:0]  count,
    output logic              silent
);
    logic             load;
    logic [CNT_W-1:0] dur;

    nlt_decode #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_decode (
        .code (dur_code),
        .dur  (dur)
    );

    nlt_change_det #(.CODE_W(CODE_W)) u_change (
        .clk  (clk),
        .rst  (rst),
        .code (dur_code),
        .load (load)
    );

    nlt_core #(.CNT_W(CNT_W)) u_core (
        .clk    (clk),
        .rst    (rst),
        .tick   (frame_tick),
        .freeze (freeze),
        .load   (load),
        .dur    (dur),
        .count  (count),
        .silent (silent)
    );

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> count == '0);
endmodule

// File: tb/note_len_timer_tb_top.sv
`timescale 1ns/1ps
module note_len_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_tick = 1'b0;
    logic       freeze = 1'b0;
    logic [4:0] dur_code = 5'd7;
    logic [7:0] count;
    logic       silent;

    int checks = 0;
    int failures = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] m_cnt = 8'd0;
    logic [4:0] m_prev = 5'd0;
    bit         done = 0;

    always #2.5 clk = ~clk;

    note_len_timer dut_i (
        .clk(clk), .rst(rst), .frame_tick(frame_tick), .freeze(freeze),
        .dur_code(dur_code), .count(count), .silent(silent)
    );

    function automatic logic [7:0] ref_len(input logic [4:0] c);
        logic [3:0] r;
        r = c[4:1];
        if (c[0]) return (r == 4'd0) ? 8'hFE : {3'd0, r, 1'b0};
        case (r)
            4'd0: return 8'd10;   4'd1: return 8'd20;   4'd2: return 8'd40;
            4'd3: return 8'd80;   4'd4: return 8'd160;  4'd5: return 8'd60;
            4'd6: return 8'd14;   4'd7: return 8'd26;   4'd8: return 8'd12;
            4'd9: return 8'd24;   4'd10: return 8'd48;  4'd11: return 8'd96;
            4'd12: return 8'd192; 4'd13: return 8'd72;  4'd14: return 8'd16;
            default: return 8'd32;
        endcase
    endfunction

    // Driver: apply one cycle of stimulus, predict, push expectation.
    task automatic step(input bit r, input logic [4:0] c, input bit t,
                        input bit f, input string tag);
        @(negedge clk);
        rst = r; dur_code = c; frame_tick = t; freeze = f;
        @(posedge clk);
        if (r) m_cnt = 8'd0;
        else if (c != m_prev) m_cnt = ref_len(c);
        else if (t && !f && m_cnt != 8'd0) m_cnt = m_cnt - 8'd1;
        m_prev = c;
        exp_q.push_back(m_cnt);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare away from the active edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [7:0] e;
            string tg;
            e = exp_q.pop_front();
            tg = tag_q.pop_front();
            checks++;
            if (count !== e) begin
                failures++;
                $display("FAIL %s count actual=%0d expected=%0d", tg, count, e);
            end
            checks++;
            if (silent !== (e == 8'd0)) begin
                failures++;
                $display("FAIL R9 (%s) silent actual=%0b expected=%0b", tg, silent, e == 8'd0);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state and no startup load for an unchanged code
        step(1, 5'd7, 0, 0, "R1");
        step(1, 5'd7, 0, 0, "R1");
        for (int i = 0; i < 3; i++) step(0, 5'd7, 1, 0, "R1");
        // R2 / R3: every code, each a change
        for (int c = 0; c < 32; c++) begin
            if (c == 7) step(0, 5'd6, 0, 0, "R2");
            step(0, 5'(c), 0, 0, (c % 2 == 0) ? "R2" : "R3");
        end
        // R4: held code does not reload
        for (int i = 0; i < 3; i++) step(0, 5'd31, 0, 0, "R4");
        // R5: decrement on ticks only
        step(0, 5'd2, 0, 0, "R4");
        for (int i = 0; i < 3; i++) step(0, 5'd2, 1, 0, "R5");
        step(0, 5'd2, 0, 0, "R5");
        step(0, 5'd2, 1, 0, "R5");
        // R6: freeze holds under ticks
        for (int i = 0; i < 3; i++) step(0, 5'd2, 1, 1, "R6");
        step(0, 5'd2, 1, 0, "R5");
        // R8: load with tick
        step(0, 5'd8, 1, 0, "R8");
        step(0, 5'd9, 1, 1, "R8");
        // R7: drain small count and keep ticking
        step(0, 5'd3, 1, 0, "R8");
        for (int i = 0; i < 5; i++) step(0, 5'd3, 1, 0, "R7");
        // R7: drain the longest entry
        step(0, 5'd1, 0, 0, "R3");
        for (int i = 0; i < 258; i++) step(0, 5'd1, 1, 0, "R7");
        // R1: reset mid-count with a code change
        step(0, 5'd24, 0, 0, "R2");
        step(1, 5'd5, 0, 0, "R1");
        step(0, 5'd5, 1, 0, "R1");
        step(0, 5'd4, 0, 0, "R4");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule